// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a microcontroller's write bus and an on-chip flash core. It watches every byte written to the flash address space and recognises the command sequences that start a byte program or a whole-array erase. A write only starts an operation when the full sequence arrives with the expected data bytes at the expected unlock offsets. A faulty sequence is dropped, and the decoder waits for a fresh one.

Each array has its own sequencer. Any array can be switched into a fast-program mode that needs only two writes per byte. In that mode the array accepts no other command until the software sends the exit pair. Only one operation runs at a time. While it runs, the decoder holds ready low, ignores all writes, and answers reads of the busy array with a status byte built from polling, toggle and error flags.

The flash core reports the end of an operation with `done_i`, and with `fail_i` when the operation failed. A failure leaves the error flag visible until the next write.

Top module: `flash_cmd_dec`

## Requirements
- R1: A write of AAh to offset 555h, then 55h to offset AAAh, then A0h to any offset, then a fourth write of any data and any offset in the same array makes `prog_start_o` high for exactly the one cycle after that fourth write. In that cycle `op_bank_o`, `op_addr_o` and `op_data_o` hold the array, offset and data of the fourth write.
- R2: `ready_o` is 0 from the cycle in which a start pulse appears until the clock edge at which `done_i` is sampled high. At all other times it is 1, including while an error is being shown.
- R3: In either unlock write, a wrong data byte or a wrong offset sends the array back to read mode. The writes that follow are decoded from the start.
- R4: After the two unlock writes, a write of 20h sets `bypass_o[array]` to 1 from the next cycle on.
- R5: In fast-program mode, a write of A0h to any offset followed by a write of data to an offset starts a program of that offset and data, as in R1. The mode is kept afterwards.
- R6: In fast-program mode, every write other than A0h or the exit pair is ignored. This includes full erase sequences, and 90h followed by any byte other than 00h. No start pulse occurs and the mode stays set.
- R7: In fast-program mode, 90h followed by 00h clears `bypass_o[array]`. Program sequences that use A0h without the unlock writes have no effect after that.
- R8: The bulk erase sequence is AAh@555h, 55h@AAAh, 80h, AAh@555h, 55h@AAAh, 10h. It makes `erase_start_o` high for one cycle, with `op_bank_o` set to the array and `op_addr_o` set to 0 whatever offset the last write used.
- R9: A wrong data byte or unlock offset anywhere in the erase sequence aborts it, so the final 10h starts nothing.
- R10: While `ready_o` is 0, every write is ignored. No start pulse follows, and no array changes mode.
- R11: While an operation runs, a read of its array returns these bits: bit 7 is the complement of bit 7 of the programmed data (0 for an erase); bit 6 starts at 0 and inverts after every cycle with `rd_i` high; bit 5 is 0; bits 4:0 come from `array_data_i`. Reads of other arrays, and reads when no operation or error is pending, return `array_data_i` unchanged.
- R12: If `fail_i` is high when `done_i` is sampled, reads of that array keep the status format with bit 5 = 1. The next write clears this state and is itself not decoded.
- R13: After reset `ready_o` is 1, `bypass_o` is 0, and both start pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| bank_i | input | BW | Array select for writes and reads |
| addr_i | input | AW | Offset within the selected array |
| data_i | input | 8 | Write data byte |
| rd_i | input | 1 | Read strobe, advances the toggle bit |
| array_data_i | input | 8 | Read data from the flash core |
| done_i | input | 1 | Operation complete, from the core |
| fail_i | input | 1 | Operation failed, qualified by done_i |
| prog_start_o | output | 1 | One-cycle program start pulse |
| erase_start_o | output | 1 | One-cycle bulk erase start pulse |
| op_bank_o | output | BW | Array of the current operation |
| op_addr_o | output | AW | Offset to program, 0 for an erase |
| op_data_o | output | 8 | Data to program, FFh for an erase |
| bypass_o | output | NB | Fast-program mode per array |
| ready_o | output | 1 | 1 when no operation is running |
| rd_data_o | output | 8 | Read data: array data or status |

## Verification
The bench builds the decoder with its defaults: two arrays and 16-bit offsets. With two arrays, one array can sit in fast-program mode while the other completes a normal program, and reads of the idle array can be checked during an operation on the other. The 16-bit offset lets the final erase write use a high offset such as 7ABCh, which shows that the erase address is forced to 0. The same width leaves room for wrong unlock offsets that differ from 555h and AAAh only in low bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3,
    S_BYP, S_BYP_PROG, S_BYP_RST
  } seq_state_e;

  localparam logic [7:0] CMD_KEY1     = 8'hAA;
  localparam logic [7:0] CMD_KEY2     = 8'h55;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_FAST     = 8'h20;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_BULK     = 8'h10;
  localparam logic [7:0] CMD_FAST_X1  = 8'h90;
  localparam logic [7:0] CMD_FAST_X2  = 8'h00;
  localparam logic [7:0] ERASE_DATA   = 8'hFF;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int unsigned UNL_ADDR_A = 'h555,
  parameter int unsigned UNL_ADDR_B = 'hAAA
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          prog_req_o,
  output logic          erase_req_o,
  output logic          bypass_o
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNL_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNL_ADDR_B);

  seq_state_e state_q, state_d;
  logic key1_ok, key2_ok;

  assign key1_ok = (data_i == CMD_KEY1) && (addr_i == ADDR_A);
  assign key2_ok = (data_i == CMD_KEY2) && (addr_i == ADDR_B);

  always_comb begin
    state_d     = state_q;
    prog_req_o  = 1'b0;
    erase_req_o = 1'b0;
    if (wr_i) begin
      unique case (state_q)
        S_READ: if (key1_ok) state_d = S_UNL1;
        S_UNL1: state_d = key2_ok ? S_UNL2 : S_READ;
        S_UNL2: begin
          unique case (data_i)
            CMD_PROG:  state_d = S_PROG;
            CMD_FAST:  state_d = S_BYP;
            CMD_ERASE: state_d = S_ER1;
            default:   state_d = S_READ;
          endcase
        end
        S_PROG: begin
          prog_req_o = 1'b1;
          state_d    = S_READ;
        end
        S_ER1: state_d = key1_ok ? S_ER2 : S_READ;
        S_ER2: state_d = key2_ok ? S_ER3 : S_READ;
        S_ER3: begin
          erase_req_o = (data_i == CMD_BULK);
          state_d     = S_READ;
        end
        // fast mode: anything but the two legal commands is dropped
        S_BYP: begin
          if (data_i == CMD_PROG)         state_d = S_BYP_PROG;
          else if (data_i == CMD_FAST_X1) state_d = S_BYP_RST;
        end
        S_BYP_PROG: begin
          prog_req_o = 1'b1;
          state_d    = S_BYP;
        end
        S_BYP_RST: state_d = (data_i == CMD_FAST_X2) ? S_READ : S_BYP;
        default:   state_d = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_READ;
    else         state_q <= state_d;
  end

  assign bypass_o = (state_q == S_BYP) || (state_q == S_BYP_PROG) ||
                    (state_q == S_BYP_RST);
endmodule

// File: rtl/flash_cmd_stat.sv
module flash_cmd_stat
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 1
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          start_prog_i,
  input  logic          start_erase_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          rd_i,
  input  logic [7:0]    array_data_i,
  input  logic          done_i,
  input  logic          fail_i,
  output logic          prog_start_o,
  output logic          erase_start_o,
  output logic [BW-1:0] op_bank_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic          ready_o,
  output logic          blocked_o,
  output logic [7:0]    rd_data_o
);
  logic          busy_q, err_q, tog_q, prog_q, erase_q;
  logic [BW-1:0] bank_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          start, status_sel;

  assign start      = start_prog_i | start_erase_i;
  assign status_sel = (busy_q | err_q) && (bank_i == bank_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      bank_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      prog_q  <= start_prog_i;
      erase_q <= start_erase_i;
      if (start) begin
        busy_q <= 1'b1;
        bank_q <= bank_i;
        addr_q <= start_erase_i ? '0 : addr_i;
        data_q <= start_erase_i ? ERASE_DATA : data_i;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
        err_q  <= fail_i;
      end else if (err_q && wr_i) begin
        err_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_q <= 1'b0;
    else if (start)              tog_q <= 1'b0;
    else if (rd_i && status_sel) tog_q <= ~tog_q;
  end

  assign rd_data_o     = status_sel ? {~data_q[7], tog_q, err_q, array_data_i[4:0]}
                                    : array_data_i;
  assign prog_start_o  = prog_q;
  assign erase_start_o = erase_q;
  assign op_bank_o     = bank_q;
  assign op_addr_o     = addr_q;
  assign op_data_o     = data_q;
  assign ready_o       = ~busy_q;
  assign blocked_o     = busy_q | err_q;
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec #(
  parameter int NB = 2,
  parameter int AW = 16,
  parameter int unsigned UNL_ADDR_A = 'h555,
  parameter int unsigned UNL_ADDR_B = 'hAAA,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
)(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          rd_i,
  input  logic [7:0]    array_data_i,
  input  logic          done_i,
  input  logic          fail_i,
  output logic          prog_start_o,
  output logic          erase_start_o,
  output logic [BW-1:0] op_bank_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic [NB-1:0] bypass_o,
  output logic          ready_o,
  output logic [7:0]    rd_data_o
);
  logic          blocked, accept;
  logic [NB-1:0] bank_wr, prog_vec, erase_vec;

  assign accept = wr_i & ~blocked;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign bank_wr[g] = accept && (bank_i == BW'(g));
    flash_cmd_seq #(
      .AW(AW), .UNL_ADDR_A(UNL_ADDR_A), .UNL_ADDR_B(UNL_ADDR_B)
    ) seq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bank_wr[g]),
      .addr_i     (addr_i),
      .data_i     (data_i),
      .prog_req_o (prog_vec[g]),
      .erase_req_o(erase_vec[g]),
      .bypass_o   (bypass_o[g])
    );
  end

  flash_cmd_stat #(.AW(AW), .BW(BW)) stat_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .start_prog_i (|prog_vec),
    .start_erase_i(|erase_vec),
    .bank_i       (bank_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .rd_i         (rd_i),
    .array_data_i (array_data_i),
    .done_i       (done_i),
    .fail_i       (fail_i),
    .prog_start_o (prog_start_o),
    .erase_start_o(erase_start_o),
    .op_bank_o    (op_bank_o),
    .op_addr_o    (op_addr_o),
    .op_data_o    (op_data_o),
    .ready_o      (ready_o),
    .blocked_o    (blocked),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int NB = 2,
  parameter int AW = 16
)(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          prog_start_o,
  input logic          erase_start_o,
  input logic          ready_o,
  input logic [AW-1:0] op_addr_o,
  input logic [NB-1:0] bypass_o
);
  assert_start_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, erase_start_o}));

  assert_busy_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o || erase_start_o) |-> !ready_o);

  assert_no_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !(prog_start_o || erase_start_o));

  assert_mode_hold_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(bypass_o));

  assert_erase_addr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> (op_addr_o == '0));
endmodule

bind flash_cmd_dec flash_cmd_chk #(.NB(NB), .AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prog_start_o (prog_start_o),
  .erase_start_o(erase_start_o),
  .ready_o      (ready_o),
  .op_addr_o    (op_addr_o),
  .bypass_o     (bypass_o)
);

// File: tb/flash_cmd_dec_tb_top.sv
module flash_cmd_dec_tb_top;
  localparam int NB = 2;
  localparam int AW = 16;
  localparam int BW = 1;
  localparam logic [7:0] MEM = 8'hC3;

  typedef struct packed {
    logic       wr;
    logic       dn;
    logic       bk;
    logic [15:0] ad;
    logic [7:0] d;
    logic       ep;
    logic       ee;
    logic [1:0] eb;
    logic       er;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VECS [NV] = '{
    // R1 normal program
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h55,1'b0,1'b0,2'b00,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0000,8'hA0,1'b0,1'b0,2'b00,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0123,8'h5A,1'b1,1'b0,2'b00,1'b0,4'd1},
    '{1'b0,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,2'b00,1'b1,4'd2}, // R2
    // R3 wrong unlock offset, then wrong unlock data
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0123,8'h55,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0000,8'hA0,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0010,8'h77,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h66,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0000,8'hA0,1'b0,1'b0,2'b00,1'b1,4'd3},
    '{1'b1,1'b0,1'b0,16'h0010,8'h77,1'b0,1'b0,2'b00,1'b1,4'd3},
    // R4 enter fast mode on array 1
    '{1'b1,1'b0,1'b1,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd4},
    '{1'b1,1'b0,1'b1,16'h0AAA,8'h55,1'b0,1'b0,2'b00,1'b1,4'd4},
    '{1'b1,1'b0,1'b1,16'h0000,8'h20,1'b0,1'b0,2'b10,1'b1,4'd4},
    // R5 fast program
    '{1'b1,1'b0,1'b1,16'h0005,8'hA0,1'b0,1'b0,2'b10,1'b1,4'd5},
    '{1'b1,1'b0,1'b1,16'h0040,8'h3C,1'b1,1'b0,2'b10,1'b0,4'd5},
    '{1'b0,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,2'b10,1'b1,4'd5},
    // R6 erase sequence and bad exit ignored in fast mode
    '{1'b1,1'b0,1'b1,16'h0555,8'hAA,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0AAA,8'h55,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0000,8'h80,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0555,8'hAA,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0AAA,8'h55,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0000,8'h10,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0000,8'h90,1'b0,1'b0,2'b10,1'b1,4'd6},
    '{1'b1,1'b0,1'b1,16'h0000,8'h33,1'b0,1'b0,2'b10,1'b1,4'd6},
    // R1 array 0 still programs normally while array 1 is in fast mode
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b10,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h55,1'b0,1'b0,2'b10,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0000,8'hA0,1'b0,1'b0,2'b10,1'b1,4'd1},
    '{1'b1,1'b0,1'b0,16'h0200,8'h81,1'b1,1'b0,2'b10,1'b0,4'd1},
    '{1'b0,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,2'b10,1'b1,4'd2},
    // R7 exit fast mode, then short program has no effect
    '{1'b1,1'b0,1'b1,16'h0000,8'h90,1'b0,1'b0,2'b10,1'b1,4'd7},
    '{1'b1,1'b0,1'b1,16'h0000,8'h00,1'b0,1'b0,2'b00,1'b1,4'd7},
    '{1'b1,1'b0,1'b1,16'h0000,8'hA0,1'b0,1'b0,2'b00,1'b1,4'd7},
    '{1'b1,1'b0,1'b1,16'h0040,8'h11,1'b0,1'b0,2'b00,1'b1,4'd7},
    // R9 erase with bad fifth byte
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h55,1'b0,1'b0,2'b00,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,16'h0000,8'h80,1'b0,1'b0,2'b00,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h56,1'b0,1'b0,2'b00,1'b1,4'd9},
    '{1'b1,1'b0,1'b0,16'h0000,8'h10,1'b0,1'b0,2'b00,1'b1,4'd9},
    // R8 full bulk erase
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h55,1'b0,1'b0,2'b00,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,16'h0000,8'h80,1'b0,1'b0,2'b00,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,16'h0555,8'hAA,1'b0,1'b0,2'b00,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,16'h0AAA,8'h55,1'b0,1'b0,2'b00,1'b1,4'd8},
    '{1'b1,1'b0,1'b0,16'h7ABC,8'h10,1'b0,1'b1,2'b00,1'b0,4'd8},
    '{1'b0,1'b1,1'b0,16'h0000,8'h00,1'b0,1'b0,2'b00,1'b1,4'd2}
  };

  logic          clk, rst_n;
  logic          wr, rd, done, fail;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;
  logic [7:0]    data, rd_data, op_data;
  logic          prog_start, erase_start, ready;
  logic [BW-1:0] op_bank;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] bypass;
  int            n_chk = 0, n_fail = 0;

  flash_cmd_dec #(.NB(NB), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .bank_i(bank), .addr_i(addr),
    .data_i(data), .rd_i(rd), .array_data_i(MEM), .done_i(done), .fail_i(fail),
    .prog_start_o(prog_start), .erase_start_o(erase_start), .op_bank_o(op_bank),
    .op_addr_o(op_addr), .op_data_o(op_data), .bypass_o(bypass),
    .ready_o(ready), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_cyc(input logic b, input logic [15:0] a, input logic [7:0] d);
    wr = 1'b1; bank = b; addr = a; data = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic done_cyc(input logic f);
    done = 1'b1; fail = f;
    @(posedge clk); #1;
    done = 1'b0; fail = 1'b0;
  endtask

  // sample combinational read data, then let the strobe take effect
  task automatic rd_cyc(input logic b, output logic [7:0] v);
    rd = 1'b1; bank = b; #1;
    v = rd_data;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic unlock(input logic b);
    wr_cyc(b, 16'h0555, 8'hAA);
    wr_cyc(b, 16'h0AAA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_test();
  end

  initial begin
    logic [7:0] v;
    wr = 0; rd = 0; done = 0; fail = 0; bank = 0; addr = 0; data = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R13 reset state
    check("R13 ready", ready, 1);
    check("R13 bypass", bypass, 0);
    check("R13 starts", {prog_start, erase_start}, 0);
    rd_cyc(0, v);
    check("R11 idle read", v, MEM);

    for (int i = 0; i < NV; i++) begin
      wr = VECS[i].wr; done = VECS[i].dn; bank = VECS[i].bk;
      addr = VECS[i].ad; data = VECS[i].d;
      @(posedge clk); #1;
      wr = 1'b0; done = 1'b0;
      check($sformatf("R%0d vec%0d", VECS[i].rq, i),
            {prog_start, erase_start, bypass, ready},
            {VECS[i].ep, VECS[i].ee, VECS[i].eb, VECS[i].er});
    end

    // R1 latched operands, R11 status reads during program
    unlock(0);
    wr_cyc(0, 16'h0000, 8'hA0);
    wr_cyc(0, 16'h0321, 8'h5A);
    check("R1 pulse", prog_start, 1);
    check("R1 bank", op_bank, 0);
    check("R1 addr", op_addr, 16'h0321);
    check("R1 data", op_data, 8'h5A);
    @(posedge clk); #1;
    check("R1 pulse width", prog_start, 0);
    rd_cyc(0, v);
    check("R11 first status", v, 8'h83);
    rd_cyc(0, v);
    check("R11 toggled status", v, 8'hC3);
    rd_cyc(1, v);
    check("R11 other array", v, MEM);
    done_cyc(0);
    check("R2 ready after done", ready, 1);
    rd_cyc(0, v);
    check("R11 after done", v, MEM);

    // R8 erase on array 1, R10 lockout, R12 failure
    unlock(1);
    wr_cyc(1, 16'h0000, 8'h80);
    unlock(1);
    wr_cyc(1, 16'h1234, 8'h10);
    check("R8 erase pulse", erase_start, 1);
    check("R8 erase bank", op_bank, 1);
    check("R8 erase addr", op_addr, 0);
    rd_cyc(1, v);
    check("R11 erase status", v, 8'h03);
    unlock(0);
    wr_cyc(0, 16'h0000, 8'h20);
    check("R10 no mode change", bypass, 0);
    unlock(0);
    wr_cyc(0, 16'h0000, 8'hA0);
    wr_cyc(0, 16'h0050, 8'h99);
    check("R10 no start while busy", {prog_start, erase_start}, 0);
    check("R2 busy", ready, 0);
    done_cyc(1);
    check("R2 ready during error", ready, 1);
    rd_cyc(1, v);
    check("R12 error bit", {v[7], v[5]}, 2'b01);
    // clearing write is not decoded, so the rest cannot start a program
    unlock(0);
    wr_cyc(0, 16'h0000, 8'hA0);
    wr_cyc(0, 16'h0060, 8'h42);
    check("R12 clearing write dropped", prog_start, 0);
    rd_cyc(1, v);
    check("R12 error cleared", v, MEM);

    finish_test();
  end
endmodule